// File: doc/BRIEF.md
# Scan-Testable Controlled-Swap D Latch

This block is a level-sensitive D latch built from two three-input, three-output controlled-swap primitives placed in cascade and modelled at gate level. The first primitive selects between the data input and the stored value under the enable. The second primitive sits in the storage loop and uses two test controls to either pass the stored value back (normal operation) or replace the feedback with a constant (test operation). A parameter chooses whether the latch is transparent while the enable is high or while it is low.

All six primitive output nets are brought out so that a test sequencer can compare them with expected values. A fault-injection port forces one chosen net to a stuck value, which lets a bench or sequencer show that the two constant test vectors expose any single stuck-at fault. A registered fault flag reports a mismatch between the nets and the constant the current test vector implies. The storage loop is closed through one clocked register, so the loop is evaluated once per clock cycle and the latch output is combinational from that register and the inputs.

Top module: `fdl_top`

## Requirements
- R1: Each primitive with inputs (a, b, c) drives outputs (a, a'b + ac, ab + a'c). The nets are numbered: bit 0 first pass-through of the enable, bit 1 its second output (the latch output), bit 2 its third output, bit 3 second primitive pass-through of the stored value, bit 4 its second output (the feedback), bit 5 its third output. In normal mode with stored value h these read bit0=E, bit3=h, bit4=h, bit5=h'.
- R2: With NEG_EN=0, controls c1c2=01 and enable 1, the output equals the data input in the same cycle.
- R3: With NEG_EN=0, controls 01 and enable 0, the output holds the value it had at the previous clock edge.
- R4: With NEG_EN=1 the latch is transparent while enable is 0 and holds while enable is 1.
- R5: With data, enable, c1 and c2 all 1 and no fault, all six nets read 1 and the fault flag stays 0.
- R6: With data, enable, c1 and c2 all 0 and no fault, all six nets read 0 and the fault flag stays 0.
- R7: With fault injection enabled, net number faultIdx reads faultVal; with it disabled, the nets are fault-free.
- R8: The fault flag is registered. Once a test vector (c1 equal to c2) has been held for two clock edges, the flag reads 1 exactly when some net differs from c1. A stuck-at-0 on any net is therefore flagged by the all-ones vector, and a stuck-at-1 by the all-zeros vector.
- R9: The fault flag reads 0 at every clock edge that follows an edge taken in normal mode.
- R10: Reset (rst_n low) clears the stored value and the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop evaluation clock |
| rst_n | input | 1 | Active-low reset |
| dIn | input | 1 | Data input |
| enIn | input | 1 | Latch enable |
| c1In | input | 1 | First test control |
| c2In | input | 1 | Second test control |
| faultEn | input | 1 | Enables fault injection |
| faultIdx | input | 3 | Net number to force |
| faultVal | input | 1 | Stuck value to force |
| qOut | output | 1 | Latch output |
| netsOut | output | 6 | All primitive output nets |
| faultFlag | output | 1 | Registered test mismatch flag |

## Verification
The bench builds two instances side by side: one with NEG_EN=0 and one with NEG_EN=1. Both take the same data and test controls, so the transparent and hold phases of both enable polarities, and the net values each gate ordering produces, are compared on the same random sequence. With both polarities present, every one of the six nets can be forced to both stuck values under both test vectors. This shows that each vector flags its own fault class and stays silent for the other.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  localparam int NUM_NETS = 6;
  localparam int IDX_W = $clog2(NUM_NETS);

  localparam int NET_G1_PASS = 0;
  localparam int NET_G1_SEL = 1;
  localparam int NET_G1_ALT = 2;
  localparam int NET_G2_PASS = 3;
  localparam int NET_G2_FB = 4;
  localparam int NET_G2_ALT = 5;

  typedef struct packed {
    logic testMode;   // c1 == c2: feedback replaced by a constant
    logic expectVal;  // constant every net should read in test mode
    logic modeHeld;   // same control code as at the previous edge
  } ctrlStrobe_t;
endpackage

// File: rtl/fdl_swap_gate.sv
module fdl_swap_gate (
  input  logic ctlA,
  input  logic inB,
  input  logic inC,
  output logic outP,
  output logic outQ,
  output logic outR
);
  assign outP = ctlA;
  assign outQ = (~ctlA & inB) | (ctlA & inC);
  assign outR = (ctlA & inB) | (~ctlA & inC);
endmodule

// File: rtl/fdl_ctrl.sv
module fdl_ctrl
  import fdl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        c1In,
  input  logic        c2In,
  input  logic        netDiffAny,
  output ctrlStrobe_t strobe,
  output logic        faultFlag
);
  logic [1:0] prevCode;
  logic       prevValid;

  always_comb begin
    strobe.testMode  = (c1In == c2In);
    strobe.expectVal = c1In;
    strobe.modeHeld  = prevValid && (prevCode == {c1In, c2In});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevCode  <= 2'b01;
      prevValid <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      prevCode  <= {c1In, c2In};
      prevValid <= 1'b1;
      faultFlag <= strobe.testMode && strobe.modeHeld && netDiffAny;
    end
  end

  // R9: normal mode at an edge leaves the flag clear after that edge
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.testMode |=> !faultFlag);

  // R8: the flag can only rise after an edge taken in a test mode
  a_r8_flag_from_test: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultFlag) |-> $past(strobe.testMode));
endmodule

// File: rtl/fdl_datapath.sv
module fdl_datapath
  import fdl_pkg::*;
#(
  parameter bit NEG_EN = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dIn,
  input  logic                enIn,
  input  logic                c1In,
  input  logic                c2In,
  input  logic                faultEn,
  input  logic [IDX_W-1:0]    faultIdx,
  input  logic                faultVal,
  input  ctrlStrobe_t         strobe,
  output logic                qOut,
  output logic [NUM_NETS-1:0] netsOut,
  output logic                netDiffAny
);
  logic holdReg;
  logic g1P, g1Q, g1R, g2P, g2Q, g2R;
  logic n0, n1, n2, n3, n4, n5;

  function automatic logic applyFault(input logic raw, input int k);
    return (faultEn && (int'(faultIdx) == k)) ? faultVal : raw;
  endfunction

  // loop primitive: stored value steers the two test controls
  fdl_swap_gate u_loop (
    .ctlA(holdReg), .inB(c1In), .inC(c2In),
    .outP(g2P), .outQ(g2Q), .outR(g2R)
  );

  always_comb begin
    n3 = applyFault(g2P, NET_G2_PASS);
    n4 = applyFault(g2Q, NET_G2_FB);
    n5 = applyFault(g2R, NET_G2_ALT);
  end

  // select primitive: input order fixes the enable polarity
  generate
    if (NEG_EN) begin : g_neg
      fdl_swap_gate u_sel (
        .ctlA(enIn), .inB(dIn), .inC(n4),
        .outP(g1P), .outQ(g1Q), .outR(g1R)
      );
    end else begin : g_pos
      fdl_swap_gate u_sel (
        .ctlA(enIn), .inB(n4), .inC(dIn),
        .outP(g1P), .outQ(g1Q), .outR(g1R)
      );
    end
  endgenerate

  always_comb begin
    n0 = applyFault(g1P, NET_G1_PASS);
    n1 = applyFault(g1Q, NET_G1_SEL);
    n2 = applyFault(g1R, NET_G1_ALT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) holdReg <= 1'b0;
    else        holdReg <= n1;
  end

  assign qOut       = n1;
  assign netsOut    = {n5, n4, n3, n2, n1, n0};
  assign netDiffAny = |(netsOut ^ {NUM_NETS{strobe.expectVal}});

  logic normalMode, activeEn;
  assign normalMode = !c1In && c2In;
  assign activeEn   = NEG_EN ? !enIn : enIn;

  // R2 / R4: transparent phase follows data
  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (normalMode && !faultEn && activeEn) |-> (qOut == dIn));

  // R3 / R4: opaque phase keeps the last sampled output
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (normalMode && !faultEn && !activeEn && $past(rst_n) && $past(normalMode && !faultEn))
      |-> (qOut == $past(qOut)));

  // R5 / R6: in a test mode the feedback net is the control constant
  a_r5_feedback_const: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.testMode && !faultEn) |-> (netsOut[NET_G2_FB] == c1In));

  // R7: a forced net carries the forced value
  a_r7_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (faultEn && int'(faultIdx) < NUM_NETS) |-> (netsOut[faultIdx] == faultVal));
endmodule

// File: rtl/fdl_top.sv
module fdl_top
  import fdl_pkg::*;
#(
  parameter bit NEG_EN = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dIn,
  input  logic                enIn,
  input  logic                c1In,
  input  logic                c2In,
  input  logic                faultEn,
  input  logic [IDX_W-1:0]    faultIdx,
  input  logic                faultVal,
  output logic                qOut,
  output logic [NUM_NETS-1:0] netsOut,
  output logic                faultFlag
);
  ctrlStrobe_t strobe;
  logic        netDiffAny;

  fdl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .c1In(c1In), .c2In(c2In),
    .netDiffAny(netDiffAny), .strobe(strobe), .faultFlag(faultFlag)
  );

  fdl_datapath #(.NEG_EN(NEG_EN)) u_dp (
    .clk(clk), .rst_n(rst_n), .dIn(dIn), .enIn(enIn),
    .c1In(c1In), .c2In(c2In), .faultEn(faultEn), .faultIdx(faultIdx),
    .faultVal(faultVal), .strobe(strobe), .qOut(qOut),
    .netsOut(netsOut), .netDiffAny(netDiffAny)
  );
endmodule

// File: tb/sim_fdl_top.sv
module sim_fdl_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d = 1'b0, eP = 1'b0, eN = 1'b1, c1 = 1'b0, c2 = 1'b1;
  logic fEn = 1'b0, fVal = 1'b0;
  logic [2:0] fIdx = 3'd0;
  logic qP, qN, flagP, flagN;
  logic [5:0] netsP, netsN;
  logic holdP, holdN;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdl_top #(.NEG_EN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .dIn(d), .enIn(eP), .c1In(c1), .c2In(c2),
    .faultEn(fEn), .faultIdx(fIdx), .faultVal(fVal),
    .qOut(qP), .netsOut(netsP), .faultFlag(flagP));

  fdl_top #(.NEG_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .dIn(d), .enIn(eN), .c1In(c1), .c2In(c2),
    .faultEn(fEn), .faultIdx(fIdx), .faultVal(fVal),
    .qOut(qN), .netsOut(netsN), .faultFlag(flagN));

  function automatic logic [5:0] expNets(input logic neg, input logic dv,
                                         input logic ev, input logic h);
    logic act, s1, s2;
    act = neg ? ~ev : ev;
    s1 = act ? dv : h;
    s2 = act ? h : dv;
    return {~h, h, h, s2, s1, ev};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic normalStep(input logic dv, input logic ep, input logic en);
    logic [5:0] xp, xn;
    @(negedge clk);
    d = dv; eP = ep; eN = en; c1 = 1'b0; c2 = 1'b1; fEn = 1'b0;
    #1;
    xp = expNets(1'b0, dv, ep, holdP);
    xn = expNets(1'b1, dv, en, holdN);
    check("R1 nets pos", 32'(netsP), 32'(xp));
    check("R1 nets neg", 32'(netsN), 32'(xn));
    check(ep ? "R2 q pos transparent" : "R3 q pos hold", 32'(qP), 32'(xp[1]));
    check("R4 q neg", 32'(qN), 32'(xn[1]));
    @(posedge clk);
    holdP = xp[1];
    holdN = xn[1];
  endtask

  task automatic restore();
    @(negedge clk);
    fEn = 1'b0; c1 = 1'b0; c2 = 1'b1; d = 1'b0; eP = 1'b1; eN = 1'b0;
    @(posedge clk);
    holdP = 1'b0; holdN = 1'b0;
    @(negedge clk); #1;
    check("R9 flag clear pos", 32'(flagP), 32'd0);
    check("R9 flag clear neg", 32'(flagN), 32'd0);
  endtask

  task automatic testVec(input logic v, input logic fOn, input int idx, input logic fv);
    @(negedge clk);
    d = v; eP = v; eN = v; c1 = v; c2 = v;
    fEn = fOn; fIdx = 3'(idx); fVal = fv;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    if (!fOn) begin
      check(v ? "R5 ones nets pos" : "R6 zeros nets pos", 32'(netsP), v ? 32'h3f : 32'h0);
      check(v ? "R5 ones nets neg" : "R6 zeros nets neg", 32'(netsN), v ? 32'h3f : 32'h0);
      check(v ? "R5 ones flag" : "R6 zeros flag", 32'(flagP | flagN), 32'd0);
    end else begin
      check("R7 forced net pos", 32'(netsP[idx]), 32'(fv));
      check("R7 forced net neg", 32'(netsN[idx]), 32'(fv));
      check("R8 flag pos", 32'(flagP), 32'(fv != v));
      check("R8 flag neg", 32'(flagN), 32'(fv != v));
    end
    restore();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    holdP = 1'b0; holdN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R10: stored value and flag cleared by reset
    check("R10 q pos after reset", 32'(qP), 32'd0);
    check("R10 q neg after reset", 32'(qN), 32'd0);
    check("R10 flag after reset", 32'(flagP | flagN), 32'd0);

    // directed: capture 1, hold against data change, then capture 0
    normalStep(1'b1, 1'b1, 1'b0);
    normalStep(1'b0, 1'b0, 1'b1);
    normalStep(1'b0, 1'b0, 1'b1);
    normalStep(1'b0, 1'b1, 1'b0);
    normalStep(1'b1, 1'b0, 1'b1);

    for (int i = 0; i < 300; i++)
      normalStep(1'($urandom), 1'($urandom), 1'($urandom));

    // fault-free test vectors
    testVec(1'b1, 1'b0, 0, 1'b0);
    testVec(1'b0, 1'b0, 0, 1'b0);

    // every net, both stuck values, both vectors
    for (int k = 0; k < 6; k++) begin
      for (int sv = 0; sv < 2; sv++) begin
        testVec(1'b1, 1'b1, k, 1'(sv));
        testVec(1'b0, 1'b1, k, 1'(sv));
      end
    end

    // back in normal mode with injection disabled: fault-free again (R7)
    for (int i = 0; i < 40; i++)
      normalStep(1'($urandom), 1'($urandom), 1'($urandom));

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule